// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits beside the write path of a byte-wide non-volatile array and watches every host write. Fixed address/data unlock keys, sent as consecutive writes, turn a persistent protection flag on or off, authorise a burst of data writes while the flag stays on, or request a whole-array erase. For each write it says whether that write may reach the array. It also closes the current page-load window with a commit strobe.

Host writes arrive as a stream of beats. A cycle with `wr_valid` high is one beat carrying `wr_addr` and `wr_data`. The block never applies back-pressure and has no ready signal, so every beat is taken in the cycle it is presented. `wr_permit` is combinational and qualifies the beat of the same cycle. The other outputs are registered.

The protection flag models non-volatile state. Only the cold reset `por_n` clears it, to the unprotected default. The warm reset `rst_n` clears only the sequence tracking, the window and the pulse outputs. The array itself, erasing and programming are handled elsewhere.

Top module: `wprot_seq`

## Requirements
- R1: After a cold reset, `prot_on`, `erase_req` and `page_commit` are 0, and an ordinary data beat is permitted (`wr_permit`=1 in its cycle).
- R2: The lock key is three beats: AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h. It sets `prot_on` in the cycle after its last beat and opens the write gate for the rest of the current page-load window.
- R3: The release key is six beats: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h. It clears `prot_on` in the cycle after its last beat.
- R4: The erase key is the release key with 10h as its last data byte. It raises `erase_req` for exactly one cycle after the last beat, but only if the gate was open (`prot_on`=0, or the lock key opened the current window). Otherwise it has no effect.
- R5: While `prot_on`=1 and the gate is closed, data beats get `wr_permit`=0.
- R6: A beat consumed as the next expected key step always gets `wr_permit`=0, even when unprotected.
- R7: A beat that does not match the next expected step sends tracking back to the first step and leaves `prot_on` unchanged. It is judged as a data beat under the current gate.
- R8: Every beat restarts a window of WIN_CYCLES cycles. If WIN_CYCLES cycles pass with no beat, the window closes: tracking returns to the first step, the gate opened by the lock key shuts, and `page_commit` pulses for one cycle if at least one data beat was permitted in that window.
- R9: A warm reset (`rst_n` low) leaves `prot_on` unchanged. A cold reset (`por_n` low) clears it.
- R10: Data written after the lock key is permitted, and `prot_on` remains 1 after the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold reset, active low, clears the protection flag |
| rst_n | input | 1 | Warm reset, active low, keeps the protection flag |
| wr_valid | input | 1 | Write beat present this cycle |
| wr_addr | input | 17 | Beat address |
| wr_data | input | 8 | Beat data byte |
| wr_permit | output | 1 | The current beat may be written to the array |
| prot_on | output | 1 | Protection flag |
| erase_req | output | 1 | One-cycle whole-array erase request |
| page_commit | output | 1 | One-cycle strobe closing a window that held permitted writes |

## Verification
The bench goes after the key branch at the third step, where A0h and 80h split. A design that decoded this wrongly would lock on the release key or release on the lock key. It sends the erase key while locked without the lock key, which a loose gate would turn into an erase pulse. It lets the window expire in the middle of a key and then sends the remaining step. A design without the abort would complete the key, whereas a correct one takes that byte as data. It also checks that the first byte of a key is never permitted, that a broken key gives its mismatching byte back to the data path, and that a warm reset keeps the lock while a cold reset clears it.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_X3, SQ_X4, SQ_X5
  } seq_t;

  localparam logic [7:0] CODE_OPEN   = 8'hAA;
  localparam logic [7:0] CODE_PAIR   = 8'h55;
  localparam logic [7:0] CODE_LOCK   = 8'hA0;
  localparam logic [7:0] CODE_EXTEND = 8'h80;
  localparam logic [7:0] CODE_FREE   = 8'h20;
  localparam logic [7:0] CODE_WIPE   = 8'h10;
endpackage

// File: rtl/wprot_keyfsm.sv
module wprot_keyfsm
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_P = 17'h05555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 17'h02AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              abort,
  output logic              step_hit,
  output logic              lock_evt,
  output logic              free_evt,
  output logic              wipe_evt
);
  seq_t state_q, state_d;
  logic at_p, at_q, hit;

  assign at_p = (addr == ADDR_P);
  assign at_q = (addr == ADDR_Q);

  always_comb begin
    hit = 1'b0;
    case (state_q)
      SQ_IDLE: hit = at_p && (data == DATA_W'(CODE_OPEN));
      SQ_K1:   hit = at_q && (data == DATA_W'(CODE_PAIR));
      SQ_K2:   hit = at_p && ((data == DATA_W'(CODE_LOCK)) || (data == DATA_W'(CODE_EXTEND)));
      SQ_X3:   hit = at_p && (data == DATA_W'(CODE_OPEN));
      SQ_X4:   hit = at_q && (data == DATA_W'(CODE_PAIR));
      SQ_X5:   hit = at_p && ((data == DATA_W'(CODE_FREE)) || (data == DATA_W'(CODE_WIPE)));
      default: hit = 1'b0;
    endcase
  end

  assign step_hit = beat && hit;
  assign lock_evt = step_hit && (state_q == SQ_K2) && (data == DATA_W'(CODE_LOCK));
  assign free_evt = step_hit && (state_q == SQ_X5) && (data == DATA_W'(CODE_FREE));
  assign wipe_evt = step_hit && (state_q == SQ_X5) && (data == DATA_W'(CODE_WIPE));

  always_comb begin
    state_d = state_q;
    if (beat) begin
      if (!hit) state_d = SQ_IDLE;
      else begin
        case (state_q)
          SQ_IDLE: state_d = SQ_K1;
          SQ_K1:   state_d = SQ_K2;
          SQ_K2:   state_d = (data == DATA_W'(CODE_LOCK)) ? SQ_IDLE : SQ_X3;
          SQ_X3:   state_d = SQ_X4;
          SQ_X4:   state_d = SQ_X5;
          default: state_d = SQ_IDLE;
        endcase
      end
    end else if (abort) begin
      state_d = SQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !beat) |=> (state_q == SQ_IDLE)); // R8
  AST_MISS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !step_hit) |=> (state_q == SQ_IDLE)); // R7
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock_evt, free_evt, wipe_evt})); // R4
endmodule

// File: rtl/wprot_window.sv
module wprot_window #(
  parameter int WIN_CYCLES = 4096,
  localparam int CNT_W = $clog2(WIN_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = !beat && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (beat)           cnt_q <= CNT_W'(WIN_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WIN_CYCLES)); // R8
  AST_BEAT_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (cnt_q == CNT_W'(WIN_CYCLES))); // R8
endmodule

// File: rtl/wprot_lock.sv
module wprot_lock (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic lock_evt,
  input  logic free_evt,
  input  logic wipe_evt,
  input  logic data_beat,
  input  logic expire,
  output logic permit,
  output logic prot_on,
  output logic erase_req,
  output logic page_commit
);
  logic prot_q, unlock_q, pend_q, erase_q, commit_q;
  logic gate;

  assign gate   = !prot_q || unlock_q;
  assign permit = data_beat && gate;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        prot_q <= 1'b0;
    else if (lock_evt) prot_q <= 1'b1;
    else if (free_evt) prot_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      pend_q   <= 1'b0;
      erase_q  <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      erase_q  <= wipe_evt && gate;
      commit_q <= expire && pend_q;
      if (lock_evt)    unlock_q <= 1'b1;
      else if (expire) unlock_q <= 1'b0;
      if (expire)      pend_q <= 1'b0;
      else if (permit) pend_q <= 1'b1;
    end
  end

  assign prot_on     = prot_q;
  assign erase_req   = erase_q;
  assign page_commit = commit_q;

  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!por_n)
    lock_evt |=> prot_on); // R2
  AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    free_evt |=> !prot_on); // R3
  AST_PROT_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    (!lock_evt && !free_evt) |=> $stable(prot_on)); // R7
  AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req); // R4
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    page_commit |=> !page_commit); // R8
endmodule

// File: rtl/wprot_seq.sv
module wprot_seq #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int WIN_CYCLES = 4096,
  parameter logic [ADDR_W-1:0] ADDR_P = 17'h05555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 17'h02AAA
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_permit,
  output logic              prot_on,
  output logic              erase_req,
  output logic              page_commit
);
  logic rst_all_n, step_hit, lock_evt, free_evt, wipe_evt, expire;

  assign rst_all_n = rst_n && por_n;

  wprot_keyfsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_P(ADDR_P), .ADDR_Q(ADDR_Q)) u_keys (
    .clk(clk), .rst_n(rst_all_n), .beat(wr_valid), .addr(wr_addr), .data(wr_data),
    .abort(expire), .step_hit(step_hit), .lock_evt(lock_evt), .free_evt(free_evt),
    .wipe_evt(wipe_evt));

  wprot_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_all_n), .beat(wr_valid), .expire(expire));

  wprot_lock u_lock (
    .clk(clk), .por_n(por_n), .rst_n(rst_all_n), .lock_evt(lock_evt),
    .free_evt(free_evt), .wipe_evt(wipe_evt), .data_beat(wr_valid && !step_hit),
    .expire(expire), .permit(wr_permit), .prot_on(prot_on),
    .erase_req(erase_req), .page_commit(page_commit));

  AST_KEY_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_all_n)
    step_hit |-> !wr_permit); // R6
  AST_PERMIT_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_all_n)
    wr_permit |-> wr_valid); // R5
endmodule

// File: tb/wprot_seq_bench.sv
module wprot_seq_bench;
  localparam int WIN = 8;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_permit, prot_on, erase_req, page_commit;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_step = 0, m_cnt = 0;
  bit m_prot = 0, m_unlock = 0, m_pend = 0, m_erase = 0, m_commit = 0;

  always #10 clk = ~clk;

  wprot_seq #(.WIN_CYCLES(WIN)) u_wprot_seq (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_permit(wr_permit), .prot_on(prot_on),
    .erase_req(erase_req), .page_commit(page_commit));

  function automatic bit key_match(int st, logic [16:0] a, logic [7:0] d);
    logic [16:0] want_a;
    want_a = (st == 1 || st == 4) ? 17'h02AAA : 17'h05555;
    if (a != want_a) return 0;
    case (st)
      0, 3: return d == 8'hAA;
      1, 4: return d == 8'h55;
      2:    return d == 8'hA0 || d == 8'h80;
      5:    return d == 8'h20 || d == 8'h10;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit v, logic [16:0] a, logic [7:0] d);
    bit gate, hit, n_erase, n_commit;
    wr_valid = v; wr_addr = a; wr_data = d;
    #1;
    gate = !m_prot || m_unlock;
    hit  = v && key_match(m_step, a, d);
    chk("wr_permit", wr_permit, v && !hit && gate);
    chk("prot_on", prot_on, m_prot);
    chk("erase_req", erase_req, m_erase);
    chk("page_commit", page_commit, m_commit);
    n_erase = 0; n_commit = 0;
    if (v) begin
      m_cnt = WIN;
      if (hit) begin
        if (m_step == 2 && d == 8'hA0) begin m_prot = 1; m_unlock = 1; m_step = 0; end
        else if (m_step == 5) begin
          if (d == 8'h20) m_prot = 0; else if (gate) n_erase = 1;
          m_step = 0;
        end else m_step++;
      end else begin
        m_step = 0;
        if (gate) m_pend = 1;
      end
    end else if (m_cnt > 0) begin
      if (m_cnt == 1) begin m_step = 0; m_unlock = 0; n_commit = m_pend; m_pend = 0; end
      m_cnt--;
    end
    m_erase = n_erase; m_commit = n_commit;
    @(negedge clk);
  endtask

  task automatic beat(logic [16:0] a, logic [7:0] d); cyc(1, a, d); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, '0, '0); endtask

  task automatic do_reset(bit cold);
    wr_valid = 0;
    if (cold) por_n = 0; else rst_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1; rst_n = 1;
    m_step = 0; m_cnt = 0; m_unlock = 0; m_pend = 0; m_erase = 0; m_commit = 0;
    if (cold) m_prot = 0;
  endtask

  task automatic key3(); beat(17'h05555, 8'hAA); beat(17'h02AAA, 8'h55); beat(17'h05555, 8'hA0); endtask
  task automatic key6(logic [7:0] last);
    beat(17'h05555, 8'hAA); beat(17'h02AAA, 8'h55); beat(17'h05555, 8'h80);
    beat(17'h05555, 8'hAA); beat(17'h02AAA, 8'h55); beat(17'h05555, last);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1);
    cur_req = "R1"; idle(2); beat(17'h00100, 8'h3C);
    cur_req = "R8"; idle(WIN + 2);
    cur_req = "R2"; key3();
    cur_req = "R10"; beat(17'h00180, 8'h11); beat(17'h00181, 8'h22); idle(WIN + 2);
    cur_req = "R5"; beat(17'h00200, 8'h5A); beat(17'h05555, 8'h77); idle(WIN + 2);
    cur_req = "R6"; beat(17'h05555, 8'hAA);
    cur_req = "R7"; beat(17'h00300, 8'h01); idle(WIN + 1);
    cur_req = "R4"; key6(8'h10); idle(WIN + 1);
    key3(); key6(8'h10); idle(WIN + 2);
    cur_req = "R9"; do_reset(0); idle(2);
    cur_req = "R3"; key6(8'h20); idle(WIN + 1);
    cur_req = "R4"; key6(8'h10); idle(2);
    cur_req = "R7"; beat(17'h05555, 8'hAA); beat(17'h00400, 8'h12); idle(WIN + 1);
    cur_req = "R8"; beat(17'h05555, 8'hAA); beat(17'h02AAA, 8'h55); idle(WIN + 1);
    beat(17'h05555, 8'hA0); idle(WIN + 2);
    cur_req = "R9"; key3(); idle(2); do_reset(1); idle(2);
    cur_req = "R6"; key3(); idle(WIN + 2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule